// File: doc/BRIEF.md
# LCD Pixel Format Unpacker

This block sits between a frame-buffer fetch engine and a display pipeline. It takes 32-bit words of packed pixel data and splits each word into individual pixels. Each pixel comes out either as a 24-bit RGB value or, at depths of eight bits or fewer, as a palette index that an external colour lookup stage resolves. A three-bit depth code selects the pixel size. Two ordering controls choose how pixels are laid out inside a word, and a swap control exchanges the red and blue channels. A two-bit format select input from the board sets how 16-bit pixels are decoded. The `EXTENDED` parameter selects the variant in which the depth code alone picks the 16-bit layout and also offers a 12-bit format.

The output is a valid/ready stream. Indexed pixels travel on the same stream with a flag raised, so the downstream lookup stage can stall the unpacker through the same handshake. Configuration is sampled together with each accepted word, so it may change between words without corrupting pixels already in flight. A combinational output also gives the number of source bytes that one display line occupies at the selected depth. The fetch engine uses this number as its line stride.

Top module: `lcd_pixel_unpacker`

## Requirements
- R1: Depth codes 0, 1, 2, 3 give 32, 16, 8, 4 pixels per word (1, 2, 4, 8 bits each). These pixels leave as palette indices: `px_is_index` is 1, `px_rgb[7:0]` holds the index and `px_rgb[23:8]` is zero.
- R2: With both ordering controls clear, pixel k of a word is taken from bits starting at k times the pixel size, so the least significant pixel leaves first.
- R3: When `cfg_be_pix` is 1 and `cfg_be_byte` is 0, at depths below 8 bits, the order of pixels inside each byte is reversed. Bytes are still visited from least to most significant. At other depths this control has no effect.
- R4: When `cfg_be_byte` is 1, the byte order of the word is reversed before extraction, and `cfg_be_pix` is then ignored.
- R5: Depth code 5 is 32 bits per pixel, one pixel per word, with red in bits 7:0, green in 15:8 and blue in 23:16. The output packs red in `px_rgb[23:16]`, green in `[15:8]` and blue in `[7:0]`, and `px_is_index` is 0.
- R6: When `cfg_swap_rb` is 1, red and blue are exchanged on the output for every direct-colour format that honours the swap control.
- R7: Base variant, depth code 4 (two pixels per word). `fmt_mux` = 1 gives 5-5-5-1, with red in 4:0, green in 9:5 and blue in 14:10; bit 15 is ignored. `fmt_mux` = 0 or 2 gives 5-6-5, with red in 4:0, green in 10:5 and blue in 15:11, and honours the swap control. `fmt_mux` = 3 gives 5-6-5 with red and blue always exchanged, whatever the swap control says.
- R8: Extended variant: code 4 is 5-5-5-1, code 6 is 5-6-5 and code 7 is 4-4-4 (red in 3:0, green in 7:4, blue in 11:8). All three honour the swap control and ignore `fmt_mux`. The base variant treats codes 6 and 7 as code 4.
- R9: A channel narrower than 8 bits is placed in the upper bits of its output byte, and the lower bits are zero.
- R10: `line_bytes` equals `line_width` divided by 8, 4 or 2 for codes 0, 1, 2. It equals `line_width` for code 3, `line_width` times 4 for code 5, and `line_width` times 2 for codes 4, 6 and 7.
- R11: A new word is accepted (`in_ready` high) only when no pixels are pending or when the last pixel of the current word is being taken in the same cycle. After a word's last pixel has gone, no further pixel is presented until another word arrives.
- R12: While `px_valid` is 1 and `px_ready` is 0, `px_valid`, `px_rgb` and `px_is_index` hold their values. No pixel is dropped or repeated.
- R13: After reset, `px_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_swap_rb | input | 1 | Exchange red and blue |
| cfg_be_byte | input | 1 | Reverse byte order of each word |
| cfg_be_pix | input | 1 | Reverse pixel order inside each byte |
| fmt_mux | input | 2 | Board select for 16-bit layout (base variant) |
| line_width | input | LINE_W | Pixels per display line |
| line_bytes | output | LINE_W+2 | Source bytes per display line |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Packed frame-buffer word |
| in_ready | output | 1 | Unpacker can take a word |
| px_valid | output | 1 | Output pixel valid |
| px_ready | input | 1 | Downstream takes the pixel |
| px_rgb | output | 24 | Pixel colour {R,G,B}, or index in bits 7:0 |
| px_is_index | output | 1 | Pixel is a palette index |

## Verification
A corrupted pixel counter or a wrong captured depth shows up within one word: the stream ends a pixel early or late, or `in_ready` rises while pixels are still owed. The bench checks this on every word. A wrong offset in the extraction shifter, or a wrong byte or pixel permutation, changes the very next pixel value. Each depth and ordering combination is therefore compared pixel by pixel against a model built from the requirements. A wrong 16-bit format decode shows on the first direct-colour pixel through its channel placement and its zero padding. Running both variants side by side with the same inputs separates the select-driven decode from the depth-driven one.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

   typedef enum logic [2:0] {
      PF_INDEX   = 3'd0,
      PF_RGB888  = 3'd1,
      PF_RGB5551 = 3'd2,
      PF_RGB565  = 3'd3,
      PF_RGB444  = 3'd4
   } pix_fmt_e;

   typedef struct packed {
      logic [2:0] depth;
      logic       swap_rb;
      logic       be_byte;
      logic       be_pix;
      logic [1:0] mux;
   } lpu_cfg_t;

   // Base variant folds the extended-only codes onto code 4
   function automatic logic [2:0] eff_depth(input logic [2:0] d, input logic ext);
      return (!ext && d > 3'd5) ? 3'd4 : d;
   endfunction

   function automatic logic [5:0] pix_per_word(input logic [2:0] e);
      case (e)
         3'd0:    return 6'd32;
         3'd1:    return 6'd16;
         3'd2:    return 6'd8;
         3'd3:    return 6'd4;
         3'd5:    return 6'd1;
         default: return 6'd2;
      endcase
   endfunction

   function automatic logic [2:0] log2_bits(input logic [2:0] e);
      return (e <= 3'd5) ? e : 3'd4;
   endfunction

endpackage

// File: rtl/lpu_word_hold.sv
module lpu_word_hold
   import lpu_pkg::*;
#(
   parameter int  WORD_W   = 32,
   parameter bit  EXTENDED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  lpu_cfg_t          cfg_in,
   output logic              in_ready,
   output logic              px_valid,
   input  logic              px_ready,
   output logic [WORD_W-1:0] word_q,
   output lpu_cfg_t          cfg_q,
   output logic [2:0]        eff_q,
   output logic [4:0]        pix_idx
);

   logic       busy;
   logic       fire;
   logic       last_pix;
   logic       load;
   logic [5:0] ppw;

   assign eff_q    = eff_depth(cfg_q.depth, EXTENDED);
   assign ppw      = pix_per_word(eff_q);
   assign last_pix = ({1'b0, pix_idx} == (ppw - 6'd1));
   assign fire     = busy && px_ready;
   assign in_ready = !busy || (fire && last_pix);
   assign load     = in_valid && in_ready;
   assign px_valid = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         pix_idx <= '0;
         word_q  <= '0;
         cfg_q   <= '0;
      end else if (load) begin
         busy    <= 1'b1;
         pix_idx <= '0;
         word_q  <= in_word;
         cfg_q   <= cfg_in;
      end else if (fire) begin
         if (last_pix) busy <= 1'b0;
         else          pix_idx <= pix_idx + 5'd1;
      end
   end

   // Independent count of pixels handed out since the last load
   logic [6:0] done_cnt;
   logic       had_word;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_cnt <= '0;
         had_word <= 1'b0;
      end else if (load) begin
         done_cnt <= '0;
         had_word <= 1'b1;
      end else if (fire) begin
         done_cnt <= done_cnt + 7'd1;
      end
   end

   // R11
   word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && had_word) |-> ((done_cnt + {6'd0, fire}) == {1'b0, ppw}));

   // R11
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ({1'b0, pix_idx} < ppw));

endmodule

// File: rtl/lpu_pixel_pick.sv
module lpu_pixel_pick #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] word,
   input  logic              be_byte,
   input  logic              be_pix,
   input  logic [2:0]        eff,
   input  logic [4:0]        pix_idx,
   output logic [WORD_W-1:0] raw
);

   localparam int BYTES = WORD_W / 8;

   logic [WORD_W-1:0] swapped;
   logic [WORD_W-1:0] lane_word;
   logic [4:0]        rev_mask;
   logic [4:0]        idx;
   logic [9:0]        bit_off;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign swapped[b*8 +: 8] = word[(BYTES-1-b)*8 +: 8];
   end

   assign lane_word = be_byte ? swapped : word;

   always_comb begin
      rev_mask = '0;
      if (be_pix && !be_byte && eff < 3'd3)
         rev_mask = (5'd8 >> eff) - 5'd1;
      idx     = pix_idx ^ rev_mask;
      bit_off = {5'd0, idx} << eff_shift(eff);
      raw     = lane_word >> bit_off[4:0];
   end

   function automatic logic [2:0] eff_shift(input logic [2:0] e);
      return (e <= 3'd5) ? e : 3'd4;
   endfunction

endmodule

// File: rtl/lpu_color_expand.sv
module lpu_color_expand
   import lpu_pkg::*;
#(
   parameter bit EXTENDED = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [23:0] raw,
   input  logic [2:0]  eff,
   input  logic        swap_rb,
   input  logic [1:0]  mux,
   output logic [23:0] rgb,
   output logic        is_index
);

   pix_fmt_e   fmt;
   logic       force_bgr;
   logic [7:0] r, g, b;
   logic [7:0] idx_mask;
   logic [3:0] idx_bits;

   if (EXTENDED) begin : g_ext
      always_comb begin
         force_bgr = 1'b0;
         case (eff)
            3'd4:    fmt = PF_RGB5551;
            3'd5:    fmt = PF_RGB888;
            3'd6:    fmt = PF_RGB565;
            3'd7:    fmt = PF_RGB444;
            default: fmt = PF_INDEX;
         endcase
      end
   end else begin : g_base
      always_comb begin
         force_bgr = 1'b0;
         if (eff == 3'd5)      fmt = PF_RGB888;
         else if (eff >= 3'd4) begin
            case (mux)
               2'd1:    fmt = PF_RGB5551;
               2'd3: begin
                  fmt       = PF_RGB565;
                  force_bgr = 1'b1;
               end
               default: fmt = PF_RGB565;
            endcase
         end else              fmt = PF_INDEX;
      end
   end

   always_comb begin
      idx_bits = 4'd1 << eff[1:0];
      idx_mask = ~(8'hFF << idx_bits);
      r = '0;
      g = '0;
      b = '0;
      case (fmt)
         PF_RGB888: begin
            r = raw[7:0];
            g = raw[15:8];
            b = raw[23:16];
         end
         PF_RGB5551: begin
            r = {raw[4:0],   3'b000};
            g = {raw[9:5],   3'b000};
            b = {raw[14:10], 3'b000};
         end
         PF_RGB565: begin
            r = {raw[4:0],   3'b000};
            g = {raw[10:5],  2'b00};
            b = {raw[15:11], 3'b000};
         end
         PF_RGB444: begin
            r = {raw[3:0],   4'b0000};
            g = {raw[7:4],   4'b0000};
            b = {raw[11:8],  4'b0000};
         end
         default: ;
      endcase
      is_index = (fmt == PF_INDEX);
      if (is_index)                rgb = {16'h0000, raw[7:0] & idx_mask};
      else if (swap_rb || force_bgr) rgb = {b, g, r};
      else                         rgb = {r, g, b};
   end

   // R1
   idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eff < 3'd4) |-> (is_index && rgb[23:8] == 16'h0000));

   // R9
   pad565_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == PF_RGB565) |-> (rgb[18:16] == 3'b000 && rgb[9:8] == 2'b00 && rgb[2:0] == 3'b000));

endmodule

// File: rtl/lpu_line_bytes.sv
module lpu_line_bytes #(
   parameter int LINE_W = 12
) (
   input  logic [2:0]        eff,
   input  logic [LINE_W-1:0] line_width,
   output logic [LINE_W+1:0] line_bytes
);

   localparam int LB_W = LINE_W + 2;

   logic [LB_W-1:0] wide;
   assign wide = LB_W'(line_width);

   always_comb begin
      case (eff)
         3'd0:    line_bytes = wide >> 3;
         3'd1:    line_bytes = wide >> 2;
         3'd2:    line_bytes = wide >> 1;
         3'd3:    line_bytes = wide;
         3'd5:    line_bytes = wide << 2;
         default: line_bytes = wide << 1;
      endcase
   end

endmodule

// File: rtl/lcd_pixel_unpacker.sv
module lcd_pixel_unpacker
   import lpu_pkg::*;
#(
   parameter int LINE_W   = 12,
   parameter bit EXTENDED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_depth,
   input  logic              cfg_swap_rb,
   input  logic              cfg_be_byte,
   input  logic              cfg_be_pix,
   input  logic [1:0]        fmt_mux,
   input  logic [LINE_W-1:0] line_width,
   output logic [LINE_W+1:0] line_bytes,
   input  logic              in_valid,
   input  logic [31:0]       in_word,
   output logic              in_ready,
   output logic              px_valid,
   input  logic              px_ready,
   output logic [23:0]       px_rgb,
   output logic              px_is_index
);

   localparam int WORD_W = 32;

   if (LINE_W < 4 || LINE_W > 24) begin : g_bad_line_w
      $error("lcd_pixel_unpacker: LINE_W out of range");
   end

   lpu_cfg_t    cfg_in;
   lpu_cfg_t    cfg_q;
   logic [31:0] word_q;
   logic [31:0] raw;
   logic [2:0]  eff_q;
   logic [4:0]  pix_idx;

   assign cfg_in = '{depth: cfg_depth, swap_rb: cfg_swap_rb, be_byte: cfg_be_byte,
                     be_pix: cfg_be_pix, mux: fmt_mux};

   lpu_word_hold #(.WORD_W(WORD_W), .EXTENDED(EXTENDED)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_word  (in_word),
      .cfg_in   (cfg_in),
      .in_ready (in_ready),
      .px_valid (px_valid),
      .px_ready (px_ready),
      .word_q   (word_q),
      .cfg_q    (cfg_q),
      .eff_q    (eff_q),
      .pix_idx  (pix_idx)
   );

   lpu_pixel_pick #(.WORD_W(WORD_W)) u_pick (
      .word    (word_q),
      .be_byte (cfg_q.be_byte),
      .be_pix  (cfg_q.be_pix),
      .eff     (eff_q),
      .pix_idx (pix_idx),
      .raw     (raw)
   );

   lpu_color_expand #(.EXTENDED(EXTENDED)) u_expand (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (raw[23:0]),
      .eff      (eff_q),
      .swap_rb  (cfg_q.swap_rb),
      .mux      (cfg_q.mux),
      .rgb      (px_rgb),
      .is_index (px_is_index)
   );

   lpu_line_bytes #(.LINE_W(LINE_W)) u_bytes (
      .eff        (eff_depth(cfg_depth, EXTENDED)),
      .line_width (line_width),
      .line_bytes (line_bytes)
   );

   // R12
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && !px_ready) |=> (px_valid && $stable(px_rgb) && $stable(px_is_index)));

endmodule

// File: tb/lcd_pixel_unpacker_test.sv
module lcd_pixel_unpacker_test;

   localparam int LW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cfg_depth = '0;
   logic          cfg_swap_rb = 1'b0;
   logic          cfg_be_byte = 1'b0;
   logic          cfg_be_pix = 1'b0;
   logic [1:0]    fmt_mux = '0;
   logic [LW-1:0] line_width = '0;
   logic [LW+1:0] lb_b, lb_x;
   logic          in_valid = 1'b0;
   logic [31:0]   in_word = '0;
   logic          rdy_b, rdy_x;
   logic          pv_b, pv_x;
   logic          px_ready = 1'b0;
   logic [23:0]   rgb_b, rgb_x;
   logic          ix_b, ix_x;

   int nvec = 0;
   int nbad = 0;

   always #4 clk = ~clk;

   lcd_pixel_unpacker #(.LINE_W(LW), .EXTENDED(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_swap_rb(cfg_swap_rb),
      .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix), .fmt_mux(fmt_mux),
      .line_width(line_width), .line_bytes(lb_b), .in_valid(in_valid), .in_word(in_word),
      .in_ready(rdy_b), .px_valid(pv_b), .px_ready(px_ready), .px_rgb(rgb_b), .px_is_index(ix_b));

   lcd_pixel_unpacker #(.LINE_W(LW), .EXTENDED(1'b1)) uut_ext (
      .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_swap_rb(cfg_swap_rb),
      .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix), .fmt_mux(fmt_mux),
      .line_width(line_width), .line_bytes(lb_x), .in_valid(in_valid), .in_word(in_word),
      .in_ready(rdy_x), .px_valid(pv_x), .px_ready(px_ready), .px_rgb(rgb_x), .px_is_index(ix_x));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected pixel {is_index, rgb} built from the requirements
   function automatic logic [24:0] model(input logic [31:0] w, input int code, input bit sw,
                                         input bit bb, input bit bp, input int mux,
                                         input bit ext, input int k);
      logic [31:0] x, raw;
      logic [7:0]  r, g, b;
      int e, bits, idx, f;
      bit s;
      x = bb ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
      e = (!ext && code > 5) ? 4 : code;
      bits = (e <= 5) ? (1 << e) : 16;
      idx = k;
      if (bp && !bb && e < 3) idx = k ^ ((8 >> e) - 1);
      raw = x >> (idx * bits);
      s = sw;
      if (e <= 3) return {1'b1, 16'h0000, raw[7:0] & 8'((1 << bits) - 1)};
      if (e == 5) begin
         r = raw[7:0]; g = raw[15:8]; b = raw[23:16];
      end else begin
         if (ext) f = (e == 4) ? 0 : (e == 6) ? 1 : 2;
         else if (mux == 1) f = 0;
         else begin
            f = 1;
            if (mux == 3) s = 1'b1;
         end
         if (f == 0) begin
            r = {raw[4:0], 3'b0}; g = {raw[9:5], 3'b0}; b = {raw[14:10], 3'b0};
         end else if (f == 1) begin
            r = {raw[4:0], 3'b0}; g = {raw[10:5], 2'b0}; b = {raw[15:11], 3'b0};
         end else begin
            r = {raw[3:0], 4'b0}; g = {raw[7:4], 4'b0}; b = {raw[11:8], 4'b0};
         end
      end
      return {1'b0, s ? {b, g, r} : {r, g, b}};
   endfunction

   task automatic set_cfg(input int code, input bit sw, input bit bb, input bit bp, input int mux);
      @(negedge clk);
      cfg_depth = 3'(code); cfg_swap_rb = sw; cfg_be_byte = bb; cfg_be_pix = bp; fmt_mux = 2'(mux);
   endtask

   // Push one word and drain its pixels, comparing both variants
   task automatic run_word(input logic [31:0] w, input int n, input bit stall, input string req);
      int k = 0;
      int cyc = 0;
      logic [24:0] eb, ex;
      int code = int'(cfg_depth);
      bit sw = cfg_swap_rb, bb = cfg_be_byte, bp = cfg_be_pix;
      int mux = int'(fmt_mux);
      @(negedge clk);
      chk(rdy_b && rdy_x, "R11 idle ready", {30'd0, rdy_b, rdy_x}, 32'h3);
      in_valid = 1'b1; in_word = w;
      @(negedge clk);
      in_valid = 1'b0;
      while (k < n && cyc < 200) begin
         px_ready = stall ? ((cyc % 3) == 2) : 1'b1;
         #1;
         eb = model(w, code, sw, bb, bp, mux, 1'b0, k);
         ex = model(w, code, sw, bb, bp, mux, 1'b1, k);
         chk(pv_b && pv_x && {ix_b, rgb_b} == eb, {req, " base"}, {7'd0, ix_b, rgb_b}, {7'd0, eb});
         chk({ix_x, rgb_x} == ex, {req, " ext"}, {7'd0, ix_x, rgb_x}, {7'd0, ex});
         if (k < n - 1 || !px_ready)
            chk(!rdy_b && !rdy_x, "R11 ready while pending", {30'd0, rdy_b, rdy_x}, 32'h0);
         if (px_ready) k++;
         @(negedge clk);
         cyc++;
      end
      px_ready = 1'b1;
      #1;
      chk(!pv_b && !pv_x && k == n, "R11 no extra pixel", {30'd0, pv_b, pv_x}, 32'h0);
      px_ready = 1'b0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!pv_b && !pv_x && rdy_b && rdy_x, "R13 reset state",
          {28'd0, pv_b, pv_x, rdy_b, rdy_x}, 32'h3);
      rst_n = 1'b1;
   endtask

   task automatic t_index_le;
      set_cfg(3, 0, 0, 0, 0);
      run_word(32'h4433_2211, 4, 0, "R1 R2 8bpp");
      set_cfg(0, 0, 0, 0, 0);
      run_word(32'hA5C3_0F01, 32, 0, "R1 R2 1bpp");
      set_cfg(1, 0, 0, 0, 0);
      run_word(32'h1B6C_E4D2, 16, 0, "R1 R2 2bpp");
   endtask

   task automatic t_orders;
      set_cfg(2, 0, 0, 1, 0);
      run_word(32'h8765_4321, 8, 0, "R3 4bpp pixel order");
      set_cfg(3, 0, 0, 1, 0);
      run_word(32'h4433_2211, 4, 0, "R3 8bpp unaffected");
      set_cfg(3, 0, 1, 0, 0);
      run_word(32'h4433_2211, 4, 0, "R4 byte order");
      set_cfg(1, 0, 1, 1, 0);
      run_word(32'h1B6C_E4D2, 16, 0, "R4 byte order priority");
   endtask

   task automatic t_direct;
      set_cfg(5, 0, 0, 0, 0);
      run_word(32'h00CC_8844, 1, 0, "R5 32bpp");
      set_cfg(5, 1, 0, 0, 0);
      run_word(32'h00CC_8844, 1, 0, "R6 32bpp swap");
      for (int m = 0; m < 4; m++) begin
         set_cfg(4, 0, 0, 0, m);
         run_word(32'hF81F_87E1, 2, 0, "R7 R8 R9 16bpp");
         set_cfg(4, 1, 0, 0, m);
         run_word(32'h7C1F_83E5, 2, 0, "R6 R7 R9 16bpp swap");
      end
      set_cfg(6, 0, 0, 0, 1);
      run_word(32'hF81F_87E1, 2, 0, "R8 code 6");
      set_cfg(7, 1, 0, 0, 2);
      run_word(32'h0ABC_0123, 2, 0, "R8 R9 code 7");
   endtask

   task automatic t_stall;
      set_cfg(1, 0, 0, 0, 0);
      run_word(32'h9C3A_55F0, 16, 1, "R12 stall");
      set_cfg(4, 1, 1, 0, 0);
      run_word(32'h1234_ABCD, 2, 1, "R12 R4 stall 16bpp");
   endtask

   task automatic t_line_bytes;
      int exp_b;
      line_width = 12'd320;
      for (int c = 0; c < 8; c++) begin
         set_cfg(c, 0, 0, 0, 0);
         #1;
         case (c)
            0: exp_b = 40;  1: exp_b = 80;  2: exp_b = 160; 3: exp_b = 320;
            5: exp_b = 1280;
            default: exp_b = 640;
         endcase
         chk(int'(lb_b) == exp_b && int'(lb_x) == exp_b, "R10 line bytes", {18'd0, lb_b}, exp_b);
      end
   endtask

   initial begin
      #(8 * 150000);
      nbad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      t_reset;
      t_index_le;
      t_orders;
      t_direct;
      t_stall;
      t_line_bytes;
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule